// File: doc/BRIEF.md
# Nibble Elastic Buffer

This block carries 4-bit nibble traffic from a receiving media interface to a transmitting one without a MAC in between. Both sides share one clock. Each side has its own clock-enable strobe: a nibble is taken in only on cycles with the input strobe, and the output advances only on cycles with the output strobe. Storage is a short shift-register queue built from flip-flops. Each stage holds a data nibble, that nibble's error flag and an occupancy bit.

Elasticity comes from holding back the start of each outgoing frame. The output data-valid stays low until the queue holds at least `WATERMARK` nibbles. Once a frame has started, nibbles leave on every output-strobe cycle for as long as entries remain. This reserve absorbs a few cycles of rate mismatch over a long frame. When the queue runs out of entries after the incoming frame has ended, the output frame closes and the next frame again waits for the watermark.

When the reserve is exceeded in either direction, the damage is made visible. A nibble that arrives while the queue is full is dropped. A read from an empty queue while the incoming frame is still running emits an error nibble. Either event marks the rest of the outgoing frame with the error flag and sets a flag that stays set until reset.

Top module: `nibble_elastic_fifo`

## Requirements
- R1: After reset, `out_nib` is 0, `out_dv` and `out_err` are 0, `fault_seen` is 0 and the queue is empty.
- R2: A nibble is queued only on a cycle where `in_en` and `in_dv` are both 1. It is stored together with that cycle's `in_err`. Cycles with `in_en` low, or with `in_dv` low, queue nothing.
- R3: While no frame is being output, an `out_en` cycle starts a frame only if the queue holds at least `WATERMARK` entries before that edge. Otherwise the outputs are driven to 0 on that cycle.
- R4: Nibbles leave in arrival order, one per `out_en` cycle of a running frame, with `out_dv`=1. `out_err` is the stored error flag ORed with the frame's corruption mark. The outputs change at the edge that ends the `out_en` cycle.
- R5: On cycles with `out_en` low, the outputs hold their value and nothing leaves the queue.
- R6: A running frame ends on an `out_en` cycle that finds the queue empty while the input is idle. The input is idle when the last `in_en` cycle had `in_dv` low. On that cycle `out_dv`, `out_err` and `out_nib` go to 0 and the corruption mark clears.
- R7: An arriving nibble with the queue full and no read on the same cycle is dropped (overflow). It sets `fault_seen` and the corruption mark. From then on, every nibble output until the frame ends carries `out_err`=1.
- R8: An `out_en` cycle of a running frame that finds the queue empty while the input is still active is an underflow. It outputs `out_nib`=0, `out_dv`=1 and `out_err`=1, keeps the frame running, and sets `fault_seen` and the corruption mark.
- R9: `fault_seen` stays set from the first overflow or underflow until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous reset, active high |
| in_en | input | 1 | Input-side clock enable |
| in_nib | input | 4 | Incoming data nibble |
| in_dv | input | 1 | Incoming data valid |
| in_err | input | 1 | Incoming error flag |
| out_en | input | 1 | Output-side clock enable |
| out_nib | output | 4 | Outgoing data nibble |
| out_dv | output | 1 | Outgoing data valid |
| out_err | output | 1 | Outgoing error flag |
| fault_seen | output | 1 | Sticky overflow/underflow indication |

## Verification
The bench builds the block with `DEPTH`=4 and `WATERMARK`=3. This leaves a single spare slot above the start threshold, so an input that runs only slightly faster than the output overflows within a short frame. The low watermark relative to a slow input likewise drains the queue mid-frame, which exercises underflow. Random phases use four different strobe-rate mixes, so frames start, drain, end and restart many times. Directed cycles cover gating below the watermark and the hold behaviour when `out_en` is low.

// File: rtl/nef_pkg.sv
package nef_pkg;

    localparam int unsigned NIB_W = 4;

    typedef struct packed {
        logic [NIB_W-1:0] nib;
        logic             err;
    } nef_entry_t;

    typedef struct packed {
        logic             run;
        logic             corr;
        logic             fault;
        logic [NIB_W-1:0] nib;
        logic             dv;
        logic             err;
    } nef_rd_state_t;

    typedef struct packed {
        logic active;
    } nef_wr_state_t;

endpackage

// File: rtl/nef_stage_chain.sv
module nef_stage_chain
    import nef_pkg::*;
#(
    parameter int unsigned DEPTH = 5,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  nef_entry_t       wr_entry,
    output nef_entry_t       head,
    output logic [DEPTH-1:0] occ,
    output logic [CW-1:0]    count
);

    nef_entry_t       ent_q [DEPTH];
    nef_entry_t       ent_d [DEPTH];
    logic [DEPTH-1:0] occ_q;
    logic [DEPTH-1:0] occ_d;
    logic [CW-1:0]    widx;

    // occupancy count from the thermometer of stage flags
    always_comb begin
        count = '0;
        for (int k = 0; k < DEPTH; k++) begin
            count = count + CW'(occ_q[k]);
        end
    end

    // slot that receives the new nibble after an optional shift
    always_comb begin
        widx = pop ? (count - CW'(1)) : count;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i < DEPTH - 1) begin : g_mid
            always_comb begin
                ent_d[i] = ent_q[i];
                occ_d[i] = occ_q[i];
                if (pop) begin
                    ent_d[i] = ent_q[i+1];
                    occ_d[i] = occ_q[i+1];
                end
                if (push && (CW'(i) == widx)) begin
                    ent_d[i] = wr_entry;
                    occ_d[i] = 1'b1;
                end
            end
        end else begin : g_last
            always_comb begin
                ent_d[i] = ent_q[i];
                occ_d[i] = occ_q[i];
                if (pop) begin
                    occ_d[i] = 1'b0;
                end
                if (push && (CW'(i) == widx)) begin
                    ent_d[i] = wr_entry;
                    occ_d[i] = 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            ent_q[i] <= ent_d[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_d;
        end
    end

    assign head = ent_q[0];
    assign occ  = occ_q;

endmodule

// File: rtl/nef_write_side.sv
module nef_write_side
    import nef_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_en,
    input  logic in_dv,
    input  logic full,
    input  logic pop,
    output logic push,
    output logic ovf_evt,
    output logic in_active
);

    nef_wr_state_t st_q;
    nef_wr_state_t st_d;
    logic          arrive;

    always_comb begin
        st_d    = st_q;
        arrive  = in_en && in_dv;
        push    = arrive && (!full || pop);
        ovf_evt = arrive && full && !pop;
        if (in_en) begin
            st_d.active = in_dv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_active = st_q.active;

endmodule

// File: rtl/nef_read_ctrl.sv
module nef_read_ctrl
    import nef_pkg::*;
#(
    parameter int unsigned DEPTH     = 5,
    parameter int unsigned WATERMARK = 3,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             out_en,
    input  logic [CW-1:0]    count,
    input  nef_entry_t       head,
    input  logic             in_active,
    input  logic             ovf_evt,
    output logic             pop,
    output logic [NIB_W-1:0] out_nib,
    output logic             out_dv,
    output logic             out_err,
    output logic             fault_seen
);

    localparam logic [CW-1:0] WM = CW'(WATERMARK);

    nef_rd_state_t st_q;
    nef_rd_state_t st_d;
    logic          uflow;
    logic          fin;

    always_comb begin
        st_d  = st_q;
        pop   = 1'b0;
        uflow = 1'b0;
        fin   = 1'b0;
        if (out_en) begin
            if (!st_q.run) begin
                if (count >= WM) begin
                    st_d.run = 1'b1;
                    pop      = 1'b1;
                end else begin
                    st_d.nib = '0;
                    st_d.dv  = 1'b0;
                    st_d.err = 1'b0;
                end
            end else if (count != '0) begin
                pop = 1'b1;
            end else if (in_active) begin
                uflow = 1'b1;
            end else begin
                fin = 1'b1;
            end
        end
        if (pop) begin
            st_d.nib = head.nib;
            st_d.dv  = 1'b1;
            st_d.err = head.err | st_q.corr;
        end
        if (uflow) begin
            st_d.nib = '0;
            st_d.dv  = 1'b1;
            st_d.err = 1'b1;
        end
        if (fin) begin
            st_d.run = 1'b0;
            st_d.nib = '0;
            st_d.dv  = 1'b0;
            st_d.err = 1'b0;
        end
        st_d.corr  = (fin ? 1'b0 : (st_q.corr | uflow)) | ovf_evt;
        st_d.fault = st_q.fault | uflow | ovf_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_nib    = st_q.nib;
    assign out_dv     = st_q.dv;
    assign out_err    = st_q.err;
    assign fault_seen = st_q.fault;

endmodule

// File: rtl/nibble_elastic_fifo.sv
module nibble_elastic_fifo
    import nef_pkg::*;
#(
    parameter int unsigned DEPTH     = 5,
    parameter int unsigned WATERMARK = 3,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_en,
    input  logic [NIB_W-1:0] in_nib,
    input  logic             in_dv,
    input  logic             in_err,
    input  logic             out_en,
    output logic [NIB_W-1:0] out_nib,
    output logic             out_dv,
    output logic             out_err,
    output logic             fault_seen
);

    nef_entry_t       wr_entry;
    nef_entry_t       head;
    logic [DEPTH-1:0] occ;
    logic [CW-1:0]    count;
    logic             push;
    logic             pop;
    logic             full;
    logic             ovf_evt;
    logic             in_active;

    always_comb begin
        wr_entry.nib = in_nib;
        wr_entry.err = in_err;
        full         = (count == CW'(DEPTH));
    end

    nef_stage_chain #(.DEPTH(DEPTH)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .wr_entry (wr_entry),
        .head     (head),
        .occ      (occ),
        .count    (count)
    );

    nef_write_side u_wr (
        .clk       (clk),
        .rst       (rst),
        .in_en     (in_en),
        .in_dv     (in_dv),
        .full      (full),
        .pop       (pop),
        .push      (push),
        .ovf_evt   (ovf_evt),
        .in_active (in_active)
    );

    nef_read_ctrl #(.DEPTH(DEPTH), .WATERMARK(WATERMARK)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .out_en     (out_en),
        .count      (count),
        .head       (head),
        .in_active  (in_active),
        .ovf_evt    (ovf_evt),
        .pop        (pop),
        .out_nib    (out_nib),
        .out_dv     (out_dv),
        .out_err    (out_err),
        .fault_seen (fault_seen)
    );

endmodule

// File: rtl/nef_checker.sv
module nef_checker #(
    parameter int unsigned DEPTH     = 5,
    parameter int unsigned WATERMARK = 3,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_en,
    input logic             in_dv,
    input logic             out_en,
    input logic [3:0]       out_nib,
    input logic             out_dv,
    input logic             out_err,
    input logic             fault_seen,
    input logic [DEPTH-1:0] occ,
    input logic [CW-1:0]    count,
    input logic             pop,
    input logic             full
);

    // R2
    occ_contig_chk: assert property (@(posedge clk) disable iff (rst)
        ((occ >> 1) & ~occ) == '0);

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> $stable({out_nib, out_dv, out_err}));

    // R5
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_en && !in_en) |=> $stable(count));

    // R3
    start_wm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_dv) |-> ($past(count) >= CW'(WATERMARK)));

    // R7
    overflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_en && in_dv && full && !pop) |=> fault_seen);

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(fault_seen));

endmodule

bind nibble_elastic_fifo nef_checker #(.DEPTH(DEPTH), .WATERMARK(WATERMARK)) u_nef_chk (
    .clk        (clk),
    .rst        (rst),
    .in_en      (in_en),
    .in_dv      (in_dv),
    .out_en     (out_en),
    .out_nib    (out_nib),
    .out_dv     (out_dv),
    .out_err    (out_err),
    .fault_seen (fault_seen),
    .occ        (occ),
    .count      (count),
    .pop        (pop),
    .full       (full)
);

// File: tb/nibble_elastic_fifo_bench.sv
`timescale 1ns/1ps
module nibble_elastic_fifo_bench;

    localparam int DEPTH = 4;
    localparam int WM    = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_en = 1'b0;
    logic [3:0] in_nib = '0;
    logic       in_dv = 1'b0;
    logic       in_err = 1'b0;
    logic       out_en = 1'b0;
    logic [3:0] out_nib;
    logic       out_dv;
    logic       out_err;
    logic       fault_seen;

    int checks = 0;
    int errors = 0;

    // model state
    logic [4:0] mq[$];
    bit         m_run, m_corr, m_fault, m_act;
    logic [3:0] m_nib;
    bit         m_dv, m_er;

    always #5 clk = ~clk;

    nibble_elastic_fifo #(.DEPTH(DEPTH), .WATERMARK(WM)) u_nibble_elastic_fifo (
        .clk(clk), .rst(rst), .in_en(in_en), .in_nib(in_nib), .in_dv(in_dv),
        .in_err(in_err), .out_en(out_en), .out_nib(out_nib), .out_dv(out_dv),
        .out_err(out_err), .fault_seen(fault_seen)
    );

    task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        mq.delete();
        m_run = 0; m_corr = 0; m_fault = 0; m_act = 0;
        m_nib = '0; m_dv = 0; m_er = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_en = 0; in_dv = 0; out_en = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        // R1: reset state
        check("R1", {out_nib, out_dv, out_err}, 6'd0);
        check("R1", {5'd0, fault_seen}, 6'd0);
    endtask

    task automatic cycle(input bit ie, input bit idv, input logic [3:0] idat,
                         input bit ier, input bit oe);
        int    cnt;
        bit    pop, uf, fin, ovf;
        string tag;
        logic [4:0] e;
        @(negedge clk);
        in_en = ie; in_dv = idv; in_nib = idat; in_err = ier; out_en = oe;
        @(posedge clk);
        cnt = mq.size(); pop = 0; uf = 0; fin = 0; ovf = 0;
        tag = (ie && idv) ? "R2" : "R5";
        if (oe) begin
            if (!m_run) begin
                tag = "R3";
                if (cnt >= WM) begin m_run = 1; pop = 1; end
                else begin m_nib = 0; m_dv = 0; m_er = 0; end
            end else if (cnt > 0) begin
                pop = 1; tag = "R4";
            end else if (m_act) begin
                uf = 1; tag = "R8";
            end else begin
                fin = 1; tag = "R6";
            end
        end
        if (pop) begin
            e = mq.pop_front();
            m_nib = e[4:1]; m_dv = 1; m_er = e[0] | m_corr;
            if (m_corr) tag = "R7";
        end
        if (uf) begin m_nib = 0; m_dv = 1; m_er = 1; m_fault = 1; end
        if (fin) begin m_run = 0; m_nib = 0; m_dv = 0; m_er = 0; end
        if (ie && idv) begin
            if (cnt == DEPTH && !pop) begin ovf = 1; m_fault = 1; tag = "R7"; end
            else mq.push_back({idat, ier});
        end
        m_corr = (fin ? 1'b0 : (m_corr | uf)) | ovf;
        if (ie) m_act = idv;
        #2;
        check(tag, {out_nib, out_dv, out_err}, {m_nib, m_dv, m_er});
        check("R9", {5'd0, fault_seen}, {5'd0, m_fault});
    endtask

    task automatic random_phase(input int pin, input int pout, input int ncyc);
        int rem = 0, gap = 2;
        for (int c = 0; c < ncyc; c++) begin
            bit ie = ($urandom % 100) < pin;
            bit oe = ($urandom % 100) < pout;
            bit dv = 0;
            if (ie) begin
                if (rem > 0) begin dv = 1; rem--; end
                else if (gap > 0) gap--;
                else begin rem = 4 + $urandom % 20; gap = 1 + $urandom % 6; end
            end
            cycle(ie, dv, 4'($urandom), ($urandom % 16) == 0, oe);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        do_reset();
        // R2: in_en low or in_dv low queues nothing
        cycle(0, 1, 4'h9, 0, 0);
        cycle(1, 0, 4'h8, 0, 0);
        // fill two below watermark, out_en high: no start (R3)
        cycle(1, 1, 4'h1, 0, 0);
        cycle(1, 1, 4'h2, 1, 1);
        cycle(0, 0, 4'h0, 0, 1);
        // third nibble reaches watermark, then output starts (R3, R4)
        cycle(1, 1, 4'h3, 0, 0);
        cycle(0, 0, 4'h0, 0, 1);
        // out_en low holds outputs (R5)
        cycle(0, 0, 4'h0, 0, 0);
        cycle(0, 0, 4'h0, 0, 1);
        cycle(0, 0, 4'h0, 0, 1);
        // input still active, queue empty: underflow (R8)
        cycle(0, 0, 4'h0, 0, 1);
        // input ends, frame closes (R6)
        cycle(1, 0, 4'h0, 0, 1);
        cycle(0, 0, 4'h0, 0, 1);
        // overflow with output stalled (R7)
        do_reset();
        for (int k = 0; k < 6; k++) cycle(1, 1, 4'(k + 5), 0, 0);
        cycle(1, 0, 4'h0, 0, 0);
        for (int k = 0; k < 6; k++) cycle(0, 0, 4'h0, 0, 1);
        // random phases with differing rate mixes
        do_reset(); random_phase(90, 90, 4000);
        do_reset(); random_phase(100, 70, 4000);
        do_reset(); random_phase(60, 100, 4000);
        do_reset(); random_phase(100, 100, 4000);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule